// File: doc/BRIEF.md
# Successive-Approximation Converter Control with Serial Readout

This block is the digital side of a 10-bit successive-approximation converter that is read over a three-wire port. It has an active-low select, a host serial clock and one data line. When select falls, the block puts the track/hold into hold and starts a binary search. The search is paced by the block's own clock, not by the host clock. On each step it drives a trial code to the capacitive DAC and reads back the comparator. The analog comparator, the DAC and the reference sit outside the block.

The data line carries its own framing. It leaves high impedance and drives low while the search runs. It goes high to mark that the result is ready. After that, each falling edge of the host clock presents the next bit: the result MSB-first, then two sub-bits, then zeros for as long as select stays low. Raising select at any point floats the line. If the search is still running, it is dropped and the track/hold goes back to tracking.

Select and the serial clock come from outside the block's clock domain. Each passes through a synchronizer of `SYNC_STAGES` flops before its edges are detected.

Top module: `sar_adc_ctrl`

## Requirements
- R1: Out of reset, and from `SYNC_STAGES`+1 cycles after select rises, `sdo_oe` is 0 (line floating) and `hold` is 0.
- R2: A falling select edge takes effect exactly `SYNC_STAGES`+1 clock edges later. At that point `hold`=1, `sdo_oe`=1 and `sdo`=0, and none of these has changed one edge earlier.
- R3: While `hold` is 1, `sdo` is driven (`sdo_oe`=1) and low.
- R4: Exactly `NBITS*STEP_DIV` edges after `hold` rises, the conversion ends: `sdo` goes to 1 and `hold` returns to 0. One edge earlier, `sdo` is still 0 and `hold` still 1.
- R5: The search tests one bit per `STEP_DIV` cycles, MSB first. The first trial code has only the MSB set (512 for 10 bits). A trial bit is cleared when `cmp_hi`=1, which means the DAC is above the held input. The final code is therefore the largest code that is not above the input.
- R6: After end of conversion, the first `NBITS` host-clock falling edges present the result MSB to LSB on `sdo`. The next two falling edges present two sub-bits that are always 0. Each bit appears `SYNC_STAGES`+1 edges after its host-clock fall.
- R7: Every host-clock falling edge after the sub-bits, with select still low, gives `sdo`=0.
- R8: Raising select during a conversion aborts it: `hold` and `sdo_oe` drop. The next conversion then runs and reads out normally.
- R9: Host-clock edges during a conversion leave `sdo` at 0 and do not disturb the result that is read out afterwards.
- R10: `cmp_hi` has no effect outside a trial: `dac_code` keeps the result and the serial bits are unchanged while `cmp_hi` toggles during readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select; the falling edge starts a conversion, the rising edge ends the frame |
| sclk | input | 1 | Host serial clock; each falling edge advances the output bit |
| cmp_hi | input | 1 | Comparator: 1 when the DAC trial value is above the held input |
| hold | output | 1 | Track/hold control, 1 = hold |
| dac_code | output | NBITS | Trial code to the capacitive DAC; holds the result after conversion |
| sdo | output | 1 | Serial data value |
| sdo_oe | output | 1 | Output-enable for the data line pad; 0 = high impedance |

## Verification
Every result has a fixed latency, and the checks are timed to it exactly:
- The hold, enable and low data line follow a select fall by `SYNC_STAGES`+1 edges, and the bench checks them one edge before and exactly on that edge.
- End of conversion comes `NBITS*STEP_DIV` edges after hold rises. It is checked on that edge and on the one before.
- Each serial bit is due `SYNC_STAGES`+1 edges after its host-clock fall. The bench samples it several cycles later, at a falling clock edge and before the next host-clock edge.
- The float after select rises is checked once its synchronizer delay has passed.

// File: rtl/sar_pkg.sv
package sar_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CONV = 2'd1,
      ST_READ = 2'd2
   } sar_state_e;
endpackage

// File: rtl/sar_edge.sv
module sar_edge #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level,
   output logic rise,
   output logic fall
);
   logic prev_q;

   if (STAGES == 0) begin : g_direct
      assign level = din;
   end else begin : g_sync
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
         end else begin
            chain_q[0] <= din;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
         end
      end
      assign level = chain_q[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RESET_VAL;
      else        prev_q <= level;
   end

   assign rise = level & ~prev_q;
   assign fall = ~level & prev_q;
endmodule

// File: rtl/sar_search.sv
module sar_search #(
   parameter int NBITS    = 10,
   parameter int STEP_DIV = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             abort,
   input  logic             cmp_hi,
   output logic [NBITS-1:0] dac_code,
   output logic             busy,
   output logic             done,
   output logic [NBITS-1:0] result
);
   localparam int IDXW     = (NBITS > 1) ? $clog2(NBITS) : 1;
   localparam int CNTW     = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
   localparam int CONV_CYC = NBITS * STEP_DIV;
   localparam int RUNW     = $clog2(CONV_CYC) + 1;
   localparam logic [NBITS-1:0] MSB_ONE = {1'b1, {(NBITS-1){1'b0}}};

   logic [NBITS-1:0] dac_q, dac_d;
   logic [IDXW-1:0]  idx_q;
   logic [CNTW-1:0]  cnt_q;
   logic             busy_q;
   logic             step_end;

   assign step_end = busy_q && (cnt_q == CNTW'(STEP_DIV - 1));

   always_comb begin
      dac_d = dac_q;
      if (cmp_hi) dac_d[idx_q] = 1'b0;
      if (idx_q != '0) dac_d[idx_q - 1'b1] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         dac_q  <= '0;
         idx_q  <= '0;
         cnt_q  <= '0;
      end else if (abort) begin
         busy_q <= 1'b0;
      end else if (start) begin
         busy_q <= 1'b1;
         dac_q  <= MSB_ONE;
         idx_q  <= IDXW'(NBITS - 1);
         cnt_q  <= '0;
      end else if (busy_q) begin
         cnt_q <= step_end ? '0 : cnt_q + 1'b1;
         if (step_end) begin
            dac_q <= dac_d;
            if (idx_q == '0) busy_q <= 1'b0;
            else             idx_q  <= idx_q - 1'b1;
         end
      end
   end

   assign dac_code = dac_q;
   assign busy     = busy_q;
   assign done     = step_end && (idx_q == '0);
   assign result   = dac_d;

   // window counter for the conversion-length check
   logic [RUNW-1:0] run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      run_q <= '0;
      else if (start)  run_q <= '0;
      else if (busy_q) run_q <= run_q + 1'b1;
   end

   a_r4_conv_len: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> run_q == RUNW'(CONV_CYC - 1));
   a_r5_first_trial: assert property (@(posedge clk) disable iff (!rst_n)
      start && !abort |=> dac_code == MSB_ONE);
   a_r10_cmp_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q && !start |=> $stable(dac_code));
endmodule

// File: rtl/sar_shreg.sv
module sar_shreg #(
   parameter int NBITS    = 10,
   parameter int SUB_BITS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             load,
   input  logic             shift,
   input  logic [NBITS-1:0] result,
   output logic             sdo
);
   localparam int W = NBITS + SUB_BITS;

   logic [W-1:0] load_vec;
   logic [W-1:0] sr_q;
   logic         sdo_q;

   if (SUB_BITS == 0) begin : g_nosub
      assign load_vec = result;
   end else begin : g_sub
      assign load_vec = {result, {SUB_BITS{1'b0}}};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q  <= '0;
         sdo_q <= 1'b0;
      end else if (clear) begin
         sr_q  <= '0;
         sdo_q <= 1'b0;
      end else if (load) begin
         sr_q  <= load_vec;
         sdo_q <= 1'b1;
      end else if (shift) begin
         sdo_q <= sr_q[W-1];
         sr_q  <= {sr_q[W-2:0], 1'b0};
      end
   end

   assign sdo = sdo_q;

   a_r7_zero_tail: assert property (@(posedge clk) disable iff (!rst_n)
      shift && !clear && !load && sr_q == '0 |=> !sdo);
   a_r4_eoc_mark: assert property (@(posedge clk) disable iff (!rst_n)
      load && !clear |=> sdo);
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
   parameter int NBITS         = 10,
   parameter int SUB_BITS      = 2,
   parameter int STEP_DIV      = 8,
   parameter int SYNC_STAGES   = 2,
   parameter int CLK_PERIOD_NS = 10,
   parameter int MAX_CONV_NS   = 7500
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             sclk,
   input  logic             cmp_hi,
   output logic             hold,
   output logic [NBITS-1:0] dac_code,
   output logic             sdo,
   output logic             sdo_oe
);
   import sar_pkg::*;

   localparam int CONV_NS = NBITS * STEP_DIV * CLK_PERIOD_NS;

   if (NBITS < 2) begin : g_bad_nbits
      $error("sar_adc_ctrl: NBITS must be at least 2");
   end
   if (STEP_DIV < 2) begin : g_bad_step
      $error("sar_adc_ctrl: STEP_DIV must be at least 2");
   end
   if (SUB_BITS < 0) begin : g_bad_sub
      $error("sar_adc_ctrl: SUB_BITS must not be negative");
   end
   if (CONV_NS > MAX_CONV_NS) begin : g_bad_time
      $error("sar_adc_ctrl: conversion exceeds the allowed time");
   end

   logic cs_lvl, cs_rise, cs_fall;
   logic sk_lvl, sk_rise, sk_fall;

   sar_edge #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_cs_edge (
      .clk(clk), .rst_n(rst_n), .din(cs_n),
      .level(cs_lvl), .rise(cs_rise), .fall(cs_fall));

   sar_edge #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sk_edge (
      .clk(clk), .rst_n(rst_n), .din(sclk),
      .level(sk_lvl), .rise(sk_rise), .fall(sk_fall));

   sar_state_e state_q, state_d;
   logic start, abort, busy, done;
   logic [NBITS-1:0] result;
   logic sh_sdo;

   assign start = cs_fall && (state_q == ST_IDLE);
   assign abort = cs_rise && (state_q == ST_CONV);

   always_comb begin
      state_d = state_q;
      if (cs_rise) begin
         state_d = ST_IDLE;
      end else begin
         case (state_q)
            ST_IDLE: if (cs_fall) state_d = ST_CONV;
            ST_CONV: if (done)    state_d = ST_READ;
            default: state_d = state_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   sar_search #(.NBITS(NBITS), .STEP_DIV(STEP_DIV)) u_search (
      .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
      .cmp_hi(cmp_hi && busy), .dac_code(dac_code), .busy(busy),
      .done(done), .result(result));

   sar_shreg #(.NBITS(NBITS), .SUB_BITS(SUB_BITS)) u_shreg (
      .clk(clk), .rst_n(rst_n), .clear(start || cs_rise),
      .load(done && !cs_rise), .shift(sk_fall && state_q == ST_READ),
      .result(result), .sdo(sh_sdo));

   assign hold   = (state_q == ST_CONV);
   assign sdo_oe = (state_q != ST_IDLE);
   assign sdo    = sh_sdo;

   a_r1_float: assert property (@(posedge clk) disable iff (!rst_n)
      cs_rise |=> !sdo_oe && !hold);
   a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> hold && sdo_oe && !sdo);
   a_r3_low_conv: assert property (@(posedge clk) disable iff (!rst_n)
      hold |-> sdo_oe && !sdo);
   a_r4_eoc_high: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold) && sdo_oe |-> sdo);
   a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
      cs_rise && hold |=> !hold && !busy);
   a_r9_sclk_conv: assert property (@(posedge clk) disable iff (!rst_n)
      hold && sk_fall && !done |=> !sdo);
endmodule

// File: tb/sar_adc_ctrl_test.sv
module sar_adc_ctrl_test;
   localparam int N    = 10;
   localparam int STEP = 8;
   localparam int SYNC = 2;
   localparam int SUB  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1;
   logic sclk = 1'b0;
   logic cmp_hi;
   logic hold, sdo, sdo_oe;
   logic [N-1:0] dac_code;

   logic [N-1:0] vin = '0;
   logic force_en = 1'b0;
   logic force_val = 1'b0;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   // comparator model: 1 when the DAC trial is above the held input
   assign cmp_hi = force_en ? force_val : (dac_code > vin);

   sar_adc_ctrl #(.NBITS(N), .SUB_BITS(SUB), .STEP_DIV(STEP), .SYNC_STAGES(SYNC),
                  .CLK_PERIOD_NS(10), .MAX_CONV_NS(7500)) uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .cmp_hi(cmp_hi),
      .hold(hold), .dac_code(dac_code), .sdo(sdo), .sdo_oe(sdo_oe));

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic t_reset;
      chk(sdo_oe == 1'b0, "R1 reset float", int'(sdo_oe), 0);
      chk(hold == 1'b0, "R1 reset track", int'(hold), 0);
   endtask

   // start with exact latency checks
   task automatic start_exact;
      cs_n = 1'b0;
      tick(SYNC);
      chk(hold == 1'b0, "R2 not before latency", int'(hold), 0);
      chk(sdo_oe == 1'b0, "R2 float before latency", int'(sdo_oe), 0);
      tick(1);
      chk(hold == 1'b1, "R2 hold", int'(hold), 1);
      chk(sdo_oe == 1'b1 && sdo == 1'b0, "R2 driven low", int'({sdo_oe, sdo}), 2);
      chk(dac_code == N'(1 << (N-1)), "R5 first trial", int'(dac_code), 1 << (N-1));
   endtask

   task automatic read_out(input logic [N-1:0] exp_code, input bit cmp_noise);
      for (int b = 0; b < N + SUB + 4; b++) begin
         if (cmp_noise) begin force_en = 1'b1; force_val = b[0]; end
         sclk = 1'b1;
         tick(4);
         sclk = 1'b0;
         tick(4);
         if (b < N) begin
            chk(sdo == exp_code[N-1-b], "R6 result bit", int'(sdo), int'(exp_code[N-1-b]));
         end else if (b < N + SUB) begin
            chk(sdo == 1'b0, "R6 sub-bit", int'(sdo), 0);
         end else begin
            chk(sdo == 1'b0, "R7 trailing zero", int'(sdo), 0);
         end
         if (cmp_noise) chk(dac_code == exp_code, "R10 code kept", int'(dac_code), int'(exp_code));
      end
      force_en = 1'b0;
      cs_n = 1'b1;
      tick(SYNC + 1);
      chk(sdo_oe == 1'b0 && hold == 1'b0, "R1 float after frame", int'({sdo_oe, hold}), 0);
      tick(3);
   endtask

   task automatic t_convert(input logic [N-1:0] v, input bit cmp_noise);
      vin = v;
      start_exact();
      tick(N*STEP - 1);
      chk(sdo == 1'b0 && hold == 1'b1, "R3 low until end", int'({sdo, hold}), 1);
      tick(1);
      chk(sdo == 1'b1 && hold == 1'b0, "R4 end mark", int'({sdo, hold}), 2);
      chk(dac_code == v, "R5 final code", int'(dac_code), int'(v));
      read_out(v, cmp_noise);
   endtask

   task automatic t_sclk_in_conv(input logic [N-1:0] v);
      vin = v;
      start_exact();
      for (int k = 0; k < 5; k++) begin
         sclk = 1'b1;
         tick(3);
         sclk = 1'b0;
         tick(3);
         chk(sdo == 1'b0 && hold == 1'b1, "R9 no shift in conversion", int'({sdo, hold}), 1);
      end
      tick(N*STEP);
      chk(sdo == 1'b1, "R9 end mark", int'(sdo), 1);
      read_out(v, 1'b0);
   endtask

   task automatic t_abort(input logic [N-1:0] v);
      vin = v;
      start_exact();
      tick(20);
      cs_n = 1'b1;
      tick(SYNC + 1);
      chk(hold == 1'b0 && sdo_oe == 1'b0, "R8 abort", int'({hold, sdo_oe}), 0);
      tick(N*STEP);
      chk(sdo_oe == 1'b0, "R8 stays idle", int'(sdo_oe), 0);
      t_convert(v ^ 10'h0F0, 1'b0);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(2);
      t_reset();
      t_convert(10'h2AA, 1'b0);
      t_convert(10'h000, 1'b0);
      t_convert(10'h3FF, 1'b0);
      t_convert(10'h155, 1'b0);
      t_convert(10'h201, 1'b1);
      t_sclk_in_conv(10'h1C7);
      t_abort(10'h0A5);
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule